// File: doc/BRIEF.md
# Pipeline Bypass and Load-Use Hazard Controller

This block is the hazard-control logic for an in-order integer pipeline with fetch, decode, execute, memory and write-back stages. Registers are read in decode and written in write-back, and write-back writes through to a same-cycle decode read. Under those conditions only read-after-write dependences need handling. The block compares the source register numbers of the instructions in decode and execute against the destinations still in flight. From that comparison it drives the operand bypass selects for the execute stage and a separate bypass select for store data in the memory stage. It also drives a one-cycle stall and bubble pair for the one case that forwarding cannot cover.

An ALU result is forwarded to a dependent instruction that follows directly, with no lost cycle. The newest matching producer is always chosen. A load followed at once by an instruction that consumes the loaded value costs exactly one bubble: PC and the fetch/decode register hold, and a no-op with write-enable low enters the decode/execute register. A store whose data, and only its data, comes from the load just ahead of it does not stall. The loaded value is instead steered into the store's memory-write data one cycle later, when the store reaches the memory stage.

Top module: `hazard_ctrl`

## Requirements
- R1: Each execute operand select (`fwd_a_o` for rs1, `fwd_b_o` for rs2) is 2'b01 when the memory-stage instruction writes that register, 2'b10 when only the write-back-stage instruction writes it, and 2'b00 (register file value) otherwise.
- R2: When the memory stage and the write-back stage both write a source register, the select is 2'b01 (the memory-stage value is newer).
- R3: Register 0 never matches, and a producer whose write-enable is low is never a bypass source or a stall cause.
- R4: A load in the memory stage is never selected as an operand bypass source (select is never 2'b01 for it); the select falls through to the write-back stage or the register file.
- R5: When the execute-stage instruction is a load with write-enable high and a nonzero destination equal to the decode rs1 or rs2, `stall_o` and `bubble_o` are both high in that same cycle; `bubble_o` always equals `stall_o`.
- R6: A decode-stage store whose rs2 (data) matches the execute-stage load destination, while its rs1 does not, causes no stall.
- R7: If the execute-stage instruction is a store whose rs2 equals the destination of a load in the memory stage (write-enable high, nonzero), `st_fwd_o` is high in the next cycle and low in any cycle not preceded by that condition.
- R8: `stall_o` is never high in two consecutive cycles.
- R9: While `rst_ni` is low, `stall_o`, `bubble_o` and `st_fwd_o` are 0 and both operand selects are 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| id_rs1_i | input | AW | Decode-stage source 1 register number |
| id_rs2_i | input | AW | Decode-stage source 2 register number |
| id_is_store_i | input | 1 | Decode-stage instruction is a store (rs2 is store data) |
| ex_rs1_i | input | AW | Execute-stage source 1 register number |
| ex_rs2_i | input | AW | Execute-stage source 2 register number |
| ex_is_store_i | input | 1 | Execute-stage instruction is a store |
| ex_rd_i | input | AW | Execute-stage destination register |
| ex_we_i | input | 1 | Execute-stage register write-enable |
| ex_load_i | input | 1 | Execute-stage instruction is a load |
| mem_rd_i | input | AW | Memory-stage destination register |
| mem_we_i | input | 1 | Memory-stage register write-enable |
| mem_load_i | input | 1 | Memory-stage instruction is a load |
| wb_rd_i | input | AW | Write-back-stage destination register |
| wb_we_i | input | 1 | Write-back-stage register write-enable |
| fwd_a_o | output | 2 | Operand A bypass select: 00 register file, 01 memory stage, 10 write-back stage |
| fwd_b_o | output | 2 | Operand B bypass select, same encoding |
| st_fwd_o | output | 1 | Replace memory-stage store data with the write-back load value |
| stall_o | output | 1 | Hold PC and the fetch/decode register |
| bubble_o | output | 1 | Load a no-op into the decode/execute register |

## Verification
The assertions assume the surrounding pipeline is well formed. Stage flags describe real instructions, a load always has its write-enable high, and the memory and write-back stages advance every cycle, so a store seen in execute is the one in the memory stage on the next edge. The bench keeps to this: it drives only combinations a real instruction stream could produce, except for the deliberately held load-use pattern that probes the one-cycle stall limit. Store forwarding is checked only across a single clean advance.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_MEM = 2'b01,
    SRC_WB  = 2'b10
  } src_sel_e;

  localparam int unsigned NUM_OPERANDS = 2;
endpackage

// File: rtl/fwd_pick.sv
module fwd_pick
  import hazard_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic          en_i,
  input  logic [AW-1:0] rs_i,
  input  logic [AW-1:0] mem_rd_i,
  input  logic          mem_we_i,
  input  logic          mem_load_i,
  input  logic [AW-1:0] wb_rd_i,
  input  logic          wb_we_i,
  output logic [1:0]    sel_o
);
  logic mem_hit, wb_hit;

  // Load data is not ready at the end of EX/MEM; it is served from MEM/WB.
  assign mem_hit = mem_we_i && !mem_load_i && (mem_rd_i != '0) && (mem_rd_i == rs_i);
  assign wb_hit  = wb_we_i && (wb_rd_i != '0) && (wb_rd_i == rs_i);

  always_comb begin
    sel_o = SRC_RF;
    if (en_i) begin
      if (mem_hit)     sel_o = SRC_MEM;
      else if (wb_hit) sel_o = SRC_WB;
    end
  end
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect #(
  parameter int unsigned AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] id_rs1_i,
  input  logic [AW-1:0] id_rs2_i,
  input  logic          id_is_store_i,
  input  logic [AW-1:0] ex_rd_i,
  input  logic          ex_we_i,
  input  logic          ex_load_i,
  output logic          stall_o
);
  logic producer_ok, hit1, hit2, hazard, stall_q;

  assign producer_ok = ex_load_i && ex_we_i && (ex_rd_i != '0);
  assign hit1 = producer_ok && (id_rs1_i == ex_rd_i);
  assign hit2 = producer_ok && (id_rs2_i == ex_rd_i);

  // Store data path is covered by the late store-data bypass.
  assign hazard = hit1 || (hit2 && !id_is_store_i);

  // One bubble always suffices: after it the load sits in MEM.
  assign stall_o = rst_ni && hazard && !stall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stall_q <= 1'b0;
    else         stall_q <= stall_o;
  end
endmodule

// File: rtl/store_fwd_track.sv
module store_fwd_track #(
  parameter int unsigned AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ex_is_store_i,
  input  logic [AW-1:0] ex_rs2_i,
  input  logic [AW-1:0] mem_rd_i,
  input  logic          mem_we_i,
  input  logic          mem_load_i,
  output logic          st_fwd_o
);
  logic arm, st_fwd_q;

  assign arm = ex_is_store_i && mem_load_i && mem_we_i &&
               (mem_rd_i != '0) && (mem_rd_i == ex_rs2_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_fwd_q <= 1'b0;
    else         st_fwd_q <= arm;
  end

  assign st_fwd_o = st_fwd_q;
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hazard_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] id_rs1_i,
  input  logic [AW-1:0] id_rs2_i,
  input  logic          id_is_store_i,
  input  logic [AW-1:0] ex_rs1_i,
  input  logic [AW-1:0] ex_rs2_i,
  input  logic          ex_is_store_i,
  input  logic [AW-1:0] ex_rd_i,
  input  logic          ex_we_i,
  input  logic          ex_load_i,
  input  logic [AW-1:0] mem_rd_i,
  input  logic          mem_we_i,
  input  logic          mem_load_i,
  input  logic [AW-1:0] wb_rd_i,
  input  logic          wb_we_i,
  output logic [1:0]    fwd_a_o,
  output logic [1:0]    fwd_b_o,
  output logic          st_fwd_o,
  output logic          stall_o,
  output logic          bubble_o
);
  logic [AW-1:0] ex_rs  [NUM_OPERANDS];
  logic [1:0]    ex_sel [NUM_OPERANDS];

  assign ex_rs[0] = ex_rs1_i;
  assign ex_rs[1] = ex_rs2_i;

  for (genvar g = 0; g < NUM_OPERANDS; g++) begin : g_opnd
    fwd_pick #(.AW(AW)) u_pick (
      .en_i      (rst_ni),
      .rs_i      (ex_rs[g]),
      .mem_rd_i  (mem_rd_i),
      .mem_we_i  (mem_we_i),
      .mem_load_i(mem_load_i),
      .wb_rd_i   (wb_rd_i),
      .wb_we_i   (wb_we_i),
      .sel_o     (ex_sel[g])
    );
  end

  assign fwd_a_o = ex_sel[0];
  assign fwd_b_o = ex_sel[1];

  load_use_detect #(.AW(AW)) u_lud (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .id_rs1_i     (id_rs1_i),
    .id_rs2_i     (id_rs2_i),
    .id_is_store_i(id_is_store_i),
    .ex_rd_i      (ex_rd_i),
    .ex_we_i      (ex_we_i),
    .ex_load_i    (ex_load_i),
    .stall_o      (stall_o)
  );

  assign bubble_o = stall_o;

  store_fwd_track #(.AW(AW)) u_sft (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ex_is_store_i(ex_is_store_i),
    .ex_rs2_i     (ex_rs2_i),
    .mem_rd_i     (mem_rd_i),
    .mem_we_i     (mem_we_i),
    .mem_load_i   (mem_load_i),
    .st_fwd_o     (st_fwd_o)
  );
endmodule

// File: rtl/hazard_ctrl_chk.sv
module hazard_ctrl_chk #(
  parameter int unsigned AW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] id_rs1_i,
  input logic [AW-1:0] id_rs2_i,
  input logic          id_is_store_i,
  input logic [AW-1:0] ex_rs1_i,
  input logic [AW-1:0] ex_rs2_i,
  input logic          ex_is_store_i,
  input logic [AW-1:0] ex_rd_i,
  input logic          ex_we_i,
  input logic          ex_load_i,
  input logic [AW-1:0] mem_rd_i,
  input logic          mem_we_i,
  input logic          mem_load_i,
  input logic [AW-1:0] wb_rd_i,
  input logic          wb_we_i,
  input logic [1:0]    fwd_a_o,
  input logic [1:0]    fwd_b_o,
  input logic          st_fwd_o,
  input logic          stall_o,
  input logic          bubble_o
);
  assert_mem_wins_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_i && !mem_load_i && mem_rd_i != '0 && mem_rd_i == ex_rs1_i) |-> fwd_a_o == 2'b01);

  assert_zero_never_src_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_a_o == 2'b01) |-> (mem_we_i && mem_rd_i != '0));

  assert_no_mem_load_src_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_b_o == 2'b01) |-> !mem_load_i);

  assert_bubble_tracks_stall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bubble_o == stall_o);

  assert_store_fwd_next_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_is_store_i && mem_load_i && mem_we_i && mem_rd_i != '0 && ex_rs2_i == mem_rd_i)
      |=> st_fwd_o);

  assert_single_stall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> !stall_o);
endmodule

bind hazard_ctrl hazard_ctrl_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_hazard_ctrl.sv
`timescale 1ns/1ps
module sim_hazard_ctrl;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic id_st, ex_st, ex_we, ex_ld, mem_we, mem_ld, wb_we;
  logic [1:0] fwd_a, fwd_b;
  logic st_fwd, stall, bubble;

  hazard_ctrl #(.AW(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .id_rs1_i(id_rs1), .id_rs2_i(id_rs2), .id_is_store_i(id_st),
    .ex_rs1_i(ex_rs1), .ex_rs2_i(ex_rs2), .ex_is_store_i(ex_st),
    .ex_rd_i(ex_rd), .ex_we_i(ex_we), .ex_load_i(ex_ld),
    .mem_rd_i(mem_rd), .mem_we_i(mem_we), .mem_load_i(mem_ld),
    .wb_rd_i(wb_rd), .wb_we_i(wb_we),
    .fwd_a_o(fwd_a), .fwd_b_o(fwd_b), .st_fwd_o(st_fwd),
    .stall_o(stall), .bubble_o(bubble)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // {ex_rs1, ex_rs2, mem_rd, mem_we, mem_ld, wb_rd, wb_we, exp_a, exp_b}
  localparam int VW = 27;
  localparam int NV = 10;
  localparam logic [VW-1:0] VEC [NV] = '{
    {5'd1,  5'd2, 5'd3,  1'b1, 1'b0, 5'd4, 1'b1, 2'b00, 2'b00}, // R1 no match
    {5'd3,  5'd2, 5'd3,  1'b1, 1'b0, 5'd4, 1'b1, 2'b01, 2'b00}, // R1 mem
    {5'd1,  5'd4, 5'd3,  1'b1, 1'b0, 5'd4, 1'b1, 2'b00, 2'b10}, // R1 wb
    {5'd5,  5'd5, 5'd5,  1'b1, 1'b0, 5'd5, 1'b1, 2'b01, 2'b01}, // R2 both, mem wins
    {5'd6,  5'd6, 5'd6,  1'b0, 1'b0, 5'd6, 1'b1, 2'b10, 2'b10}, // R3 mem we low
    {5'd0,  5'd0, 5'd0,  1'b1, 1'b0, 5'd0, 1'b1, 2'b00, 2'b00}, // R3 reg 0
    {5'd7,  5'd7, 5'd7,  1'b1, 1'b1, 5'd7, 1'b1, 2'b10, 2'b10}, // R4 mem load -> wb
    {5'd7,  5'd8, 5'd7,  1'b1, 1'b1, 5'd9, 1'b1, 2'b00, 2'b00}, // R4 mem load -> rf
    {5'd9,  5'd9, 5'd3,  1'b1, 1'b0, 5'd9, 1'b0, 2'b00, 2'b00}, // R3 wb we low
    {5'd31, 5'd1, 5'd31, 1'b1, 1'b0, 5'd1, 1'b1, 2'b01, 2'b10}  // R1 mixed
  };

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic idle();
    id_rs1 = 0; id_rs2 = 0; id_st = 0;
    ex_rs1 = 0; ex_rs2 = 0; ex_st = 0; ex_rd = 0; ex_we = 0; ex_ld = 0;
    mem_rd = 0; mem_we = 0; mem_ld = 0; wb_rd = 0; wb_we = 0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<5000", cycles);
      summary();
    end
  end

  initial begin
    idle();
    // R9: hazard patterns applied while in reset
    ex_ld = 1; ex_we = 1; ex_rd = 4; id_rs1 = 4;
    ex_rs1 = 3; mem_rd = 3; mem_we = 1;
    ex_st = 1; ex_rs2 = 3;
    repeat (2) @(negedge clk);
    #1;
    chk("R9 stall in reset", stall, 0);
    chk("R9 bubble in reset", bubble, 0);
    chk("R9 fwd_a in reset", fwd_a, 0);
    chk("R9 st_fwd in reset", st_fwd, 0);
    @(negedge clk);
    idle();
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      idle();
      {ex_rs1, ex_rs2, mem_rd, mem_we, mem_ld, wb_rd, wb_we} = VEC[i][VW-1:4];
      #1;
      chk($sformatf("R1 fwd_a vec%0d", i), fwd_a, VEC[i][3:2]);
      chk($sformatf("R1 fwd_b vec%0d", i), fwd_b, VEC[i][1:0]);
    end

    // R5: load in EX, dependent on rs1 in ID
    @(negedge clk); idle();
    ex_ld = 1; ex_we = 1; ex_rd = 4; id_rs1 = 4; id_rs2 = 2;
    #1;
    chk("R5 stall rs1", stall, 1);
    chk("R5 bubble rs1", bubble, 1);
    // R8: same pattern held one more cycle
    @(negedge clk); #1;
    chk("R8 no second stall", stall, 0);
    chk("R8 no second bubble", bubble, 0);
    @(negedge clk); idle(); #1;
    chk("R5 idle no stall", stall, 0);
    // R5: dependent on rs2
    @(negedge clk); idle();
    ex_ld = 1; ex_we = 1; ex_rd = 4; id_rs1 = 1; id_rs2 = 4;
    #1;
    chk("R5 stall rs2", stall, 1);
    @(negedge clk); idle(); #1;
    // R5: ALU producer in EX never stalls
    @(negedge clk); idle();
    ex_we = 1; ex_rd = 4; id_rs1 = 4;
    #1;
    chk("R5 alu producer no stall", stall, 0);

    // R6: store whose data only depends on the load
    @(negedge clk); idle();
    ex_ld = 1; ex_we = 1; ex_rd = 4; id_st = 1; id_rs1 = 2; id_rs2 = 4;
    #1;
    chk("R6 store data no stall", stall, 0);
    @(negedge clk); id_rs1 = 4; #1;
    chk("R6 store base stalls", stall, 1);
    @(negedge clk); idle(); #1;

    // R3: load to reg 0, and load with we low
    @(negedge clk); idle();
    ex_ld = 1; ex_we = 1; ex_rd = 0; id_rs1 = 0;
    #1;
    chk("R3 reg0 load no stall", stall, 0);
    @(negedge clk); ex_we = 0; ex_rd = 5; id_rs1 = 5; #1;
    chk("R3 we low no stall", stall, 0);

    // R7: store in EX, load in MEM with matching dest
    @(negedge clk); idle();
    ex_st = 1; ex_rs2 = 6; mem_ld = 1; mem_we = 1; mem_rd = 6;
    #1;
    chk("R4 store operand not from mem load", fwd_b, 0);
    chk("R7 st_fwd not yet", st_fwd, 0);
    @(negedge clk); idle(); #1;
    chk("R7 st_fwd next cycle", st_fwd, 1);
    @(negedge clk); #1;
    chk("R7 st_fwd clears", st_fwd, 0);
    // R7: MEM is an ALU op, not a load
    @(negedge clk); idle();
    ex_st = 1; ex_rs2 = 6; mem_we = 1; mem_rd = 6;
    @(negedge clk); idle(); #1;
    chk("R7 no st_fwd for alu producer", st_fwd, 0);
    // R7: MEM load to reg 0
    @(negedge clk); idle();
    ex_st = 1; ex_rs2 = 0; mem_ld = 1; mem_we = 1; mem_rd = 0;
    @(negedge clk); idle(); #1;
    chk("R7 no st_fwd for reg0", st_fwd, 0);

    // R9: reset clears armed store forward
    @(negedge clk); idle();
    ex_st = 1; ex_rs2 = 6; mem_ld = 1; mem_we = 1; mem_rd = 6;
    @(negedge clk); idle(); rst_n = 0; #1;
    chk("R9 st_fwd cleared by reset", st_fwd, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);

    summary();
  end
endmodule